// File: doc/BRIEF.md
# Interrupt Flag and Mask Register Unit

This unit gathers three event sources of a time-keeping peripheral (a periodic tick, an alarm match and the end of a time update) into latched flags. Each flag has an enable bit. The enabled flags combine into one summary flag, and that flag drives an open-drain interrupt request. The processor learns which sources fired by reading the status register. That same read clears every flag, so no separate acknowledge write exists.

The unit also keeps a valid-contents bit for the battery-backed storage. A power-sense input forces the bit to zero while power is unstable. Once power is good, the first read of that register sets the bit. It stays set through block resets until power-sense drops again. The block reset input clears the enables, the square-wave enable and the flags, and releases the interrupt line. It leaves the hold bit, the spare control bits and the valid bit unchanged.

Access is a simple single-cycle strobe interface. Read data is combinational from the selected register while the read strobe is high. Clears and sets caused by a read take effect at the clock edge that ends the read cycle.

Top module: `rtcIrqStatus`

## Requirements
- R1: The summary flag is (PF and PIE) or (AF and AIE) or (UF and UIE). `irqOe` is high exactly when the summary flag is set. `irqData` is always 0, so the line is pulled low when enabled and floats otherwise.
- R2: An event pulse sets its flag at the next clock edge, whether its enable bit is set or not. Flags are visible in the status register.
- R3: The status register (address 1) reads the summary flag in bit 7, PF in bit 6, AF in bit 5 and UF in bit 4, with bits 3:0 zero. A read clears all three flags and the summary flag at the end of the read cycle. Writes to the status register have no effect.
- R4: An event arriving in the same cycle as a status read is kept. That read shows the old value, and the next read shows the flag set.
- R5: While `rstN` is low, PIE, AIE, UIE, the square-wave enable and all flags are cleared and `irqOe` is low. Writes are ignored, reads return 0, and reads clear nothing.
- R6: The control register is at address 0, with PIE in bit 0, AIE in bit 1, UIE in bit 2, the square-wave enable in bit 3 and the hold bit in bit 7. A write with bit 7 set forces UIE to 0, whatever bit 2 holds.
- R7: The valid register (address 2) reads the valid bit in bit 7 and 0 in bits 6:0. The valid bit is 0 while `pwrSense` is low. Writes to this register have no effect.
- R8: With `pwrSense` high, a read of the valid register sets the valid bit at the end of that read. The read itself returns the previous value. The bit is not affected by `rstN`.
- R9: Control bits 6:4 are spare bits that read back as written. The spare bits and the hold bit are cleared only while `pwrSense` is low, not by `rstN`. `holdOut` and `sqweOut` show the hold bit and the square-wave enable. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low block reset, asynchronous |
| pwrSense | input | 1 | Power good; low clears the valid bit and the power-domain control bits |
| addr | input | 2 | Register select |
| rdStb | input | 1 | Read strobe, one cycle per access |
| wrStb | input | 1 | Write strobe, one cycle per access |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while rdStb is high |
| evPeriodic | input | 1 | Periodic event pulse |
| evAlarm | input | 1 | Alarm event pulse |
| evUpdate | input | 1 | Update-ended event pulse |
| irqOe | output | 1 | Interrupt line output enable (pull low) |
| irqData | output | 1 | Interrupt line data value, always 0 |
| sqweOut | output | 1 | Square-wave enable bit |
| holdOut | output | 1 | Hold (update inhibit) bit |

## Verification
The hardest case to reach is an event pulse that lands in the same clock cycle as the status read that clears the flags. The read must report the old value while the set wins over the clear. The bench raises the read strobe and an event input together on one falling edge and samples the read data in that cycle. It then reads again to confirm the flag survived. A second difficult case is an access while reset is low. The bench asserts reset with flags pending, attempts a write and a read, and then inspects the registers after release.

// File: rtl/rtcIrqPkg.sv
package rtcIrqPkg;
  localparam int DATA_W = 8;
  localparam int EV_NUM = 3;            // index 0 update, 1 alarm, 2 periodic
  localparam int EV_UPD = 0;
  localparam int EV_ALM = 1;
  localparam int EV_PER = 2;
  localparam int STAT_FLAG_LSB = 4;     // flags occupy bits 6:4
  localparam int STAT_SUM_BIT = 7;
  localparam int VALID_BIT = 7;
  localparam int CTRL_PIE = 0;
  localparam int CTRL_AIE = 1;
  localparam int CTRL_UIE = 2;
  localparam int CTRL_SQWE = 3;
  localparam int CTRL_SPARE_LSB = 4;
  localparam int CTRL_SPARE_W = 3;
  localparam int CTRL_HOLD = 7;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_VALID = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    rdStat;
    logic    rdValid;
    regSel_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/rtcIrqCtrl.sv
module rtcIrqCtrl
  import rtcIrqPkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int VALID_ADDR = 2
) (
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStb,
  input  logic              wrStb,
  output ctlStrobe_t        stb
);
  logic hitCtrl, hitStat, hitValid;

  always_comb begin
    hitCtrl  = (addr == ADDR_W'(CTRL_ADDR));
    hitStat  = (addr == ADDR_W'(STAT_ADDR));
    hitValid = (addr == ADDR_W'(VALID_ADDR));
  end

  // Accesses are gated off entirely while the block reset is low.
  always_comb begin
    stb.wrCtrl  = rstN && wrStb && hitCtrl;
    stb.rdStat  = rstN && rdStb && hitStat;
    stb.rdValid = rstN && rdStb && hitValid;
    stb.rdSel   = SEL_NONE;
    if (rstN && rdStb) begin
      if (hitCtrl)       stb.rdSel = SEL_CTRL;
      else if (hitStat)  stb.rdSel = SEL_STAT;
      else if (hitValid) stb.rdSel = SEL_VALID;
    end
  end
endmodule

// File: rtl/rtcIrqDatapath.sv
module rtcIrqDatapath
  import rtcIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrSense,
  input  ctlStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [EV_NUM-1:0] evIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqf,
  output logic              sqwe,
  output logic              hold
);
  logic [EV_NUM-1:0]       flagQ;
  logic [EV_NUM-1:0]       enQ;
  logic                    sqweQ;
  logic                    holdQ;
  logic [CTRL_SPARE_W-1:0] spareQ;
  logic                    vrtQ;
  logic [EV_NUM-1:0]       enNext;

  // Event flags: a set in the same cycle as a clearing read wins.
  for (genvar i = 0; i < EV_NUM; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[i] <= 1'b0;
      else       flagQ[i] <= evIn[i] | (flagQ[i] & ~stb.rdStat);
    end
  end

  always_comb begin
    enNext[EV_PER] = wrData[CTRL_PIE];
    enNext[EV_ALM] = wrData[CTRL_AIE];
    enNext[EV_UPD] = wrData[CTRL_UIE] & ~wrData[CTRL_HOLD];
  end

  // Enables live in the block-reset domain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      sqweQ <= 1'b0;
    end else if (stb.wrCtrl) begin
      enQ   <= enNext;
      sqweQ <= wrData[CTRL_SQWE];
    end
  end

  // Hold and spare bits live in the power domain.
  always_ff @(posedge clk or negedge pwrSense) begin
    if (!pwrSense) begin
      holdQ  <= 1'b0;
      spareQ <= '0;
    end else if (stb.wrCtrl) begin
      holdQ  <= wrData[CTRL_HOLD];
      spareQ <= wrData[CTRL_SPARE_LSB +: CTRL_SPARE_W];
    end
  end

  always_ff @(posedge clk or negedge pwrSense) begin
    if (!pwrSense)        vrtQ <= 1'b0;
    else if (stb.rdValid) vrtQ <= 1'b1;
  end

  always_comb irqf = |(flagQ & enQ);

  always_comb begin
    rdData = '0;
    unique case (stb.rdSel)
      SEL_CTRL: begin
        rdData[CTRL_PIE]  = enQ[EV_PER];
        rdData[CTRL_AIE]  = enQ[EV_ALM];
        rdData[CTRL_UIE]  = enQ[EV_UPD];
        rdData[CTRL_SQWE] = sqweQ;
        rdData[CTRL_SPARE_LSB +: CTRL_SPARE_W] = spareQ;
        rdData[CTRL_HOLD] = holdQ;
      end
      SEL_STAT: begin
        rdData[STAT_SUM_BIT] = irqf;
        rdData[STAT_FLAG_LSB +: EV_NUM] = flagQ;
      end
      SEL_VALID: rdData[VALID_BIT] = vrtQ;
      default:   rdData = '0;
    endcase
  end

  always_comb begin
    sqwe = sqweQ;
    hold = holdQ;
  end
endmodule

// File: rtl/rtcIrqStatus.sv
module rtcIrqStatus
  import rtcIrqPkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int VALID_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrSense,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              evPeriodic,
  input  logic              evAlarm,
  input  logic              evUpdate,
  output logic              irqOe,
  output logic              irqData,
  output logic              sqweOut,
  output logic              holdOut
);
  ctlStrobe_t        stb;
  logic [EV_NUM-1:0] evIn;
  logic              irqf;

  always_comb begin
    evIn[EV_PER] = evPeriodic;
    evIn[EV_ALM] = evAlarm;
    evIn[EV_UPD] = evUpdate;
  end

  rtcIrqCtrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR), .VALID_ADDR(VALID_ADDR)
  ) ctrl_i (
    .rstN(rstN), .addr(addr), .rdStb(rdStb), .wrStb(wrStb), .stb(stb)
  );

  rtcIrqDatapath dp_i (
    .clk(clk), .rstN(rstN), .pwrSense(pwrSense), .stb(stb),
    .wrData(wrData), .evIn(evIn), .rdData(rdData),
    .irqf(irqf), .sqwe(sqweOut), .hold(holdOut)
  );

  always_comb begin
    irqOe   = irqf;
    irqData = 1'b0;
  end
endmodule

// File: rtl/rtcIrqStatusChk.sv
module rtcIrqStatusChk #(
  parameter int ADDR_W = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwrSense,
  input logic [ADDR_W-1:0] addr,
  input logic              rdStb,
  input logic              wrStb,
  input logic [7:0]        wrData,
  input logic              evPeriodic,
  input logic              evAlarm,
  input logic              evUpdate,
  input logic              irqOe,
  input logic              sqweOut,
  input logic [2:0]        flagVec,
  input logic [2:0]        enVec,
  input logic              vrt
);
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqOe |-> (flagVec != 3'b000)); // R1
  AST_PER_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    evPeriodic |=> flagVec[2]); // R2
  AST_ALM_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    evAlarm |=> flagVec[1]); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && addr == ADDR_W'(STAT_ADDR) && !evPeriodic && !evAlarm && !evUpdate)
      |=> (flagVec == 3'b000 && !irqOe)); // R3
  AST_COINCIDE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && addr == ADDR_W'(STAT_ADDR) && evUpdate) |=> flagVec[0]); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |-> (flagVec == 3'b000 && enVec == 3'b000 && !sqweOut && !irqOe)); // R5
  AST_HOLD_KILLS_UIE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && addr == ADDR_W'(CTRL_ADDR) && wrData[7]) |=> !enVec[0]); // R6
  AST_VALID_LOW: assert property (@(posedge clk)
    !pwrSense |-> !vrt); // R7
endmodule

bind rtcIrqStatus rtcIrqStatusChk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .pwrSense(pwrSense), .addr(addr),
  .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData),
  .evPeriodic(evPeriodic), .evAlarm(evAlarm), .evUpdate(evUpdate),
  .irqOe(irqOe), .sqweOut(sqweOut),
  .flagVec(dp_i.flagQ), .enVec(dp_i.enQ), .vrt(dp_i.vrtQ)
);

// File: tb/rtcIrqStatus_tb.sv
module rtcIrqStatus_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrSense = 1'b0;
  logic [1:0] addr = '0;
  logic       rdStb = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       evPeriodic = 1'b0;
  logic       evAlarm = 1'b0;
  logic       evUpdate = 1'b0;
  logic       irqOe, irqData, sqweOut, holdOut;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit finished = 0;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_VALID = 2'd2, A_NONE = 2'd3;

  always #5 clk = ~clk;

  rtcIrqStatus dut_i (
    .clk(clk), .rstN(rstN), .pwrSense(pwrSense), .addr(addr),
    .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData), .rdData(rdData),
    .evPeriodic(evPeriodic), .evAlarm(evAlarm), .evUpdate(evUpdate),
    .irqOe(irqOe), .irqData(irqData), .sqweOut(sqweOut), .holdOut(holdOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      summary();
    end
  end

  task automatic regRead(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rdStb = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic pulse(input logic p, input logic al, input logic u);
    @(negedge clk);
    evPeriodic = p; evAlarm = al; evUpdate = u;
    @(negedge clk);
    evPeriodic = 1'b0; evAlarm = 1'b0; evUpdate = 1'b0;
  endtask

  task automatic tResetState();
    logic [7:0] v;
    @(negedge clk);
    check("R5 irqOe in reset", {7'd0, irqOe}, 8'h00);
    check("R1 irqData constant", {7'd0, irqData}, 8'h00);
    pwrSense = 1'b1;
    rstN = 1'b1;
    regRead(A_CTRL, v);  check("R5 ctrl after reset", v, 8'h00);
    regRead(A_STAT, v);  check("R3 status after reset", v, 8'h00);
    regRead(A_NONE, v);  check("R9 unmapped address", v, 8'h00);
  endtask

  task automatic tMaskAndFlags();
    logic [7:0] v;
    pulse(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R2 masked periodic no irq", {7'd0, irqOe}, 8'h00);
    regRead(A_STAT, v); check("R2 periodic flag set while masked", v, 8'h40);
    regRead(A_STAT, v); check("R3 flags cleared by read", v, 8'h00);
    regWrite(A_CTRL, 8'h02);              // AIE only
    pulse(1'b0, 1'b1, 1'b1);
    @(negedge clk);
    check("R1 alarm enabled drives irq", {7'd0, irqOe}, 8'h01);
    regRead(A_STAT, v); check("R3 status layout", v, 8'hB0);
    @(negedge clk);
    check("R3 irq released after read", {7'd0, irqOe}, 8'h00);
    regWrite(A_CTRL, 8'h01);              // PIE only
    pulse(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R1 update masked no irq", {7'd0, irqOe}, 8'h00);
    regWrite(A_CTRL, 8'h05);              // PIE and UIE: pending flag now unmasked
    @(negedge clk);
    check("R1 late enable raises irq", {7'd0, irqOe}, 8'h01);
    regRead(A_STAT, v); check("R1 summary with update", v, 8'h90);
  endtask

  task automatic tCoincide();
    logic [7:0] v;
    @(negedge clk);
    addr = A_STAT; rdStb = 1'b1; evPeriodic = 1'b1;
    #1 v = rdData;
    check("R4 coincident read shows old", v, 8'h00);
    @(negedge clk);
    rdStb = 1'b0; evPeriodic = 1'b0;
    regRead(A_STAT, v); check("R4 coincident event kept", v, 8'hC0);
  endtask

  task automatic tReadOnly();
    logic [7:0] v;
    pulse(1'b0, 1'b1, 1'b0);
    regWrite(A_STAT, 8'h00);
    regRead(A_STAT, v); check("R3 status write ignored", v, 8'h20);
    regWrite(A_VALID, 8'h80);
  endtask

  task automatic tHold();
    logic [7:0] v;
    regWrite(A_CTRL, 8'hFF);
    regRead(A_CTRL, v); check("R6 hold forces uie off", v, 8'hFB);
    check("R9 hold and sqwe pins", {6'd0, holdOut, sqweOut}, 8'h03);
    regWrite(A_CTRL, 8'h74);
    regRead(A_CTRL, v); check("R9 spare bits read back", v, 8'h74);
  endtask

  task automatic tResetPriority();
    logic [7:0] v;
    regWrite(A_CTRL, 8'h87);              // hold, PIE, AIE
    pulse(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R1 irq before reset", {7'd0, irqOe}, 8'h01);
    rstN = 1'b0;
    #1 check("R5 reset releases irq", {7'd0, irqOe}, 8'h00);
    regWrite(A_CTRL, 8'h0F);
    @(negedge clk);
    addr = A_CTRL; rdStb = 1'b1;
    #1 check("R5 read returns zero in reset", rdData, 8'h00);
    @(negedge clk);
    rdStb = 1'b0;
    rstN = 1'b1;
    regRead(A_CTRL, v); check("R5 enables cleared, hold kept R9", v, 8'h80);
    check("R5 sqwe cleared", {7'd0, sqweOut}, 8'h00);
    regRead(A_STAT, v); check("R5 flags cleared by reset", v, 8'h00);
  endtask

  task automatic tValid();
    logic [7:0] v;
    pwrSense = 1'b0;
    @(negedge clk);
    pwrSense = 1'b1;
    regRead(A_VALID, v); check("R8 first read returns old", v, 8'h00);
    regRead(A_VALID, v); check("R8 set by read", v, 8'h80);
    regRead(A_CTRL, v);  check("R9 pwrSense clears hold", v, 8'h00);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    regRead(A_VALID, v); check("R8 unaffected by reset", v, 8'h80);
    pwrSense = 1'b0;
    regRead(A_VALID, v); check("R7 cleared while power low", v, 8'h00);
    pwrSense = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tResetState();
    tMaskAndFlags();
    tCoincide();
    tReadOnly();
    tHold();
    tResetPriority();
    tValid();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule